// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Flag and Enable Controller

This block collects three interrupt causes of a clock/calendar peripheral and presents them to a processor through one active-low request line. The three causes are an alarm match, a periodic tick and an end-of-update event. The alarm and update-ended causes arrive as single-cycle event pulses from the timekeeping logic elsewhere in the chip. The periodic cause is made here. A free-running counter advances on a 32.768 kHz reference strobe, and a 4-bit rate code picks a power-of-two period between about 122 µs and 500 ms.

Each cause has a sticky flag. The flag latches whenever its event occurs, whether or not the cause is enabled, so software can poll it. Software reads the flag register to learn which causes fired, and that read clears every flag. A cause drives the request line only while its enable bit is set. A flag that was already pending when its enable is written to 1 pulls the request low at once.

The register interface is a small parallel bus with a 2-bit address, a write strobe, a read strobe and a combinational read-data return.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the rate code (address 0), the enable register (address 1) and the flag register (address 2) all read as 0x00, and irqN is 1.
- R2: An event pulse sets its flag whether or not it is enabled; the flag register (address 2) shows update-ended at bit 4, alarm at bit 5 and periodic at bit 6 from the cycle after the pulse.
- R3: The enable register (address 1, bits 6/5/4 for periodic/alarm/update-ended) gates the request; a set flag whose enable is 0 leaves irqN at 1.
- R4: Writing a 1 to the enable bit of a flag that is already set drives irqN to 0 in the cycle after the write.
- R5: A read of address 2 returns the flags with bit 7 equal to the OR of each flag ANDed with its enable; at the end of that read cycle all flags clear, and irqN returns to 1.
- R6: An event arriving in the same cycle as a flag read is not lost: its flag is set after the read.
- R7: For rate codes 3 to 15 the periodic flag sets on the 2^(code-1)-th reference strobe after the rate code is written (code 3: 4 strobes, code 4: 8 strobes); a rate write restarts the count.
- R8: Rate codes 1 and 2 behave as codes 8 and 9 (128 and 256 reference strobes).
- R9: Rate code 0 stops the periodic tick; no number of reference strobes sets the periodic flag.
- R10: irqN stays 0 while an enabled flag is set; it returns to 1 only when the flags are read or the matching enable is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| alarmEvt | input | 1 | One-cycle alarm-match event pulse |
| updateEvt | input | 1 | One-cycle end-of-update event pulse |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of address 2 clears the flags) |
| addr | input | 2 | Register address: 0 rate code, 1 enables, 2 flags |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event that lands in the very cycle of a flag read. The old flag value must be returned and cleared, while the new event must still survive. The bench raises the alarm strobe on the same clock as the read strobe. It checks that the returned byte does not yet contain the alarm flag, and that the next read does. The periodic boundaries are reached by counting reference strobes one at a time from a rate write. The irqN line is sampled one strobe before and exactly at the expected period, including the aliased codes.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int RATE_W   = 4;
  localparam int NUM_SRC  = 3;
  localparam int FLAG_LSB = 4;   // sources occupy bits 6:4 of enable and flag registers
  localparam int SUM_BIT  = 7;

  // source index inside the 3-bit vectors
  localparam int SRC_UPD = 0;
  localparam int SRC_ALM = 1;
  localparam int SRC_PER = 2;

  localparam logic [ADDR_W-1:0] ADR_RATE = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd2;

  typedef struct packed {
    logic wrRate;
    logic wrEnable;
    logic rdFlags;
  } busStrobes_t;
endpackage

// File: rtl/rtc_irq_bus_ctrl.sv
module rtc_irq_bus_ctrl
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output busStrobes_t       strobes
);
  always_comb begin
    strobes          = '0;
    strobes.wrRate   = wrEn && (addr == ADR_RATE);
    strobes.wrEnable = wrEn && (addr == ADR_EN);
    strobes.rdFlags  = rdEn && !wrEn && (addr == ADR_FLAG);
  end

  // strobes address distinct registers, never two at once
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrRate, strobes.wrEnable, strobes.rdFlags})); // R5
endmodule

// File: rtl/rtc_irq_rate_div.sv
module rtc_irq_rate_div
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              restart,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tick
);
  localparam int SHIFT_W = $clog2(DIV_W + 1);

  logic [DIV_W-1:0]   divCnt;
  logic [DIV_W-1:0]   divMask;
  logic [RATE_W-1:0]  effCode;
  logic [SHIFT_W-1:0] shiftAmt;
  logic               running;

  always_comb begin
    case (rateSel)
      4'd1:    effCode = 4'd8;
      4'd2:    effCode = 4'd9;
      default: effCode = rateSel;
    endcase
    running  = (effCode != '0);
    shiftAmt = running ? SHIFT_W'(effCode - 4'd1) : '0;
    divMask  = DIV_W'((32'd1 << shiftAmt) - 32'd1);
    tick     = running && refTick && ((divCnt & divMask) == divMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      divCnt <= '0;
    else if (restart || !running)
      divCnt <= '0;
    else if (refTick)
      divCnt <= divCnt + 1'b1;
  end

  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (rateSel == '0) |-> !tick); // R9
  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> refTick); // R7
endmodule

// File: rtl/rtc_irq_datapath.sv
module rtc_irq_datapath
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RATE_W-1:0] wrRateVal,
  input  logic [NUM_SRC-1:0] wrEnVal,
  input  logic              perTick,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  output logic [RATE_W-1:0] rateSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  logic [NUM_SRC-1:0] srcEn;
  logic [NUM_SRC-1:0] srcFlag;
  logic [NUM_SRC-1:0] srcEvt;
  logic               summary;

  always_comb begin
    srcEvt          = '0;
    srcEvt[SRC_UPD] = updateEvt;
    srcEvt[SRC_ALM] = alarmEvt;
    srcEvt[SRC_PER] = perTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel <= '0;
      srcEn   <= '0;
      srcFlag <= '0;
    end else begin
      if (strobes.wrRate)   rateSel <= wrRateVal;
      if (strobes.wrEnable) srcEn   <= wrEnVal;
      srcFlag <= (strobes.rdFlags ? '0 : srcFlag) | srcEvt;
    end
  end

  assign summary = |(srcFlag & srcEn);
  assign irqN    = !summary;

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_RATE: rdData[RATE_W-1:0] = rateSel;
      ADR_EN:   rdData[FLAG_LSB +: NUM_SRC] = srcEn;
      ADR_FLAG: begin
        rdData[FLAG_LSB +: NUM_SRC] = srcFlag;
        rdData[SUM_BIT]             = summary;
      end
      default:  rdData = '0;
    endcase
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_chk
    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rstN)
      srcEvt[s] |=> srcFlag[s]); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (srcFlag[s] && !strobes.rdFlags) |=> srcFlag[s]); // R10
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdFlags && (srcEvt == '0)) |=> (irqN && (srcFlag == '0))); // R5
  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdFlags && alarmEvt) |=> srcFlag[SRC_ALM]); // R6
  AST_ENABLE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEnable && ((wrEnVal & srcFlag) != '0)) |=> !irqN); // R4
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int DIV_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              alarmEvt,
  input  logic              updateEvt,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqN
);
  busStrobes_t       strobes;
  logic [RATE_W-1:0] rateSel;
  logic              perTick;
  logic              unusedWrBits;

  assign unusedWrBits = ^{wrData[DATA_W-1], wrData[FLAG_LSB-1:RATE_W]};

  rtc_irq_bus_ctrl i_busCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobes (strobes)
  );

  rtc_irq_rate_div #(.DIV_W(DIV_W)) i_rateDiv (
    .clk     (clk),
    .rstN    (rstN),
    .refTick (refTick),
    .restart (strobes.wrRate),
    .rateSel (rateSel),
    .tick    (perTick)
  );

  rtc_irq_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addr      (addr),
    .wrRateVal (wrData[RATE_W-1:0]),
    .wrEnVal   (wrData[FLAG_LSB +: NUM_SRC]),
    .perTick   (perTick),
    .alarmEvt  (alarmEvt),
    .updateEvt (updateEvt),
    .rateSel   (rateSel),
    .rdData    (rdData),
    .irqN      (irqN)
  );
endmodule

// File: tb/test_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module test_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0, alarmEvt = 1'b0, updateEvt = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqN;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rtc_irq_ctrl i_rtc_irq_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .alarmEvt(alarmEvt),
    .updateEvt(updateEvt), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqN(irqN)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // peek without clearing (addresses 0/1) or read-and-clear (address 2)
  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulseAlarm();
    @(negedge clk); alarmEvt = 1'b1; @(negedge clk); alarmEvt = 1'b0;
  endtask

  task automatic pulseUpdate();
    @(negedge clk); updateEvt = 1'b1; @(negedge clk); updateEvt = 1'b0;
  endtask

  task automatic pulseRef(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refTick = 1'b1; @(negedge clk); refTick = 1'b0;
    end
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 irqN", {7'd0, irqN}, 8'h01);
    regRead(2'd0, d); check("R1 rate", d, 8'h00);
    regRead(2'd1, d); check("R1 enable", d, 8'h00);
    regRead(2'd2, d); check("R1 flags", d, 8'h00);
  endtask

  task automatic testPollNoEnable();
    logic [7:0] d;
    pulseUpdate();
    check("R3 masked irqN", {7'd0, irqN}, 8'h01);
    regRead(2'd2, d); check("R2 update flag", d, 8'h10);
    pulseAlarm();
    check("R3 masked alarm irqN", {7'd0, irqN}, 8'h01);
    regRead(2'd2, d); check("R2 alarm flag", d, 8'h20);
    regRead(2'd2, d); check("R5 cleared", d, 8'h00);
  endtask

  task automatic testPendingEnable();
    logic [7:0] d;
    pulseAlarm();
    check("R4 before enable", {7'd0, irqN}, 8'h01);
    regWrite(2'd1, 8'h20);
    check("R4 enable pending", {7'd0, irqN}, 8'h00);
    repeat (5) @(negedge clk);
    check("R10 held", {7'd0, irqN}, 8'h00);
    regWrite(2'd1, 8'h00);
    check("R10 enable cleared", {7'd0, irqN}, 8'h01);
    regWrite(2'd1, 8'h20);
    check("R10 re-enabled", {7'd0, irqN}, 8'h00);
    regRead(2'd1, d); check("R3 enable readback", d, 8'h20);
    regRead(2'd2, d); check("R5 summary read", d, 8'hA0);
    check("R5 irqN after read", {7'd0, irqN}, 8'h01);
    regRead(2'd2, d); check("R5 flags empty", d, 8'h00);
  endtask

  task automatic testReadCollision();
    logic [7:0] d;
    pulseUpdate();
    @(negedge clk); rdEn = 1'b1; addr = 2'd2; alarmEvt = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0; alarmEvt = 1'b0;
    check("R6 old value", d, 8'h10);
    check("R6 irq from kept alarm", {7'd0, irqN}, 8'h00);
    regRead(2'd2, d); check("R6 alarm kept", d, 8'hA0);
    regWrite(2'd1, 8'h00);
  endtask

  task automatic periodCase(input string req, input logic [3:0] code, input int period);
    logic [7:0] d;
    regWrite(2'd1, 8'h40);
    regWrite(2'd0, {4'd0, code});
    regRead(2'd0, d); check({req, " rate readback"}, d, {4'd0, code});
    pulseRef(period - 1);
    check({req, " before period"}, {7'd0, irqN}, 8'h01);
    pulseRef(1);
    check({req, " at period"}, {7'd0, irqN}, 8'h00);
    regRead(2'd2, d); check({req, " periodic flag"}, d, 8'hC0);
    regWrite(2'd0, 8'h00);
  endtask

  task automatic testRateOff();
    logic [7:0] d;
    regWrite(2'd0, 8'h00);
    pulseRef(300);
    check("R9 irqN off", {7'd0, irqN}, 8'h01);
    regRead(2'd2, d); check("R9 no periodic flag", d, 8'h00);
    regWrite(2'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPollNoEnable();
    testPendingEnable();
    testReadCollision();
    periodCase("R7 code3", 4'd3, 4);
    periodCase("R7 code4", 4'd4, 8);
    periodCase("R8 code1", 4'd1, 128);
    periodCase("R8 code2", 4'd2, 256);
    testRateOff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule